// File: doc/BRIEF.md
# SYSREF Phase Alignment Sequencer

This block lines up a periodic SYSREF pulse with a chosen edge of the reference timing clock. It works in two stages. In the coarse stage it drives a synchronization output to the external clock generator, which resets that part's output dividers. SYSREF then falls within one converter clock period of the wanted edge, and that remaining period of doubt is what the fine stage has to remove.

In the fine stage the block walks an external tap-programmable input delay line upward from tap zero. At each tap it waits for the line to settle. It then samples the delayed SYSREF a fixed number of times with the local clock and reduces those samples to a single bit by majority vote. The first tap whose bit rises from 0 to 1 is taken as the SYSREF phase. From that phase the block computes a fine-delay code and sends it to the clock generator through a register-write request carrying an address and data.

A coarse-only mode skips the sweep. In that mode the block writes a stored edge index into the generator's coarse-delay register, so the latency stays the same from one power-up to the next. If a sweep finds no rising transition, the block flags an error and writes nothing.

Top module: `sysref_phase_aligner`

## Requirements
- R1: A `start` seen while the block is idle drives `sync_out` high for exactly SYNC_LEN cycles, beginning in the cycle after `start`. A `start` seen while `busy` is high is ignored, so it produces no second sync pulse and does not change the result.
- R2: In fine mode, the first `dly_load` pulse comes SYNC_WAIT cycles after `sync_out` falls. The sweep loads taps 0, 1, 2 and so on, with exactly one single-cycle `dly_load` pulse per tap and `dly_tap` holding that tap's value during the pulse.
- R3: At each tap the block waits SETTLE cycles after the load and then takes SAMPLES samples of `sysref_smp`. Consecutive `dly_load` pulses are therefore exactly 1+SETTLE+SAMPLES cycles apart.
- R4: A tap reads as 1 only when strictly more than SAMPLES/2 of its samples are high. A tap where exactly half of the samples are high reads as 0.
- R5: The measured edge is the first tap that reads 1 directly after a tap that reads 0. The sweep stops at that tap, and `meas_tap` reports it once `done` is high.
- R6: In fine mode the write carries address FINE_ADDR (default 0x12). Its data is the fine code ((TARGET_TAP − edge) mod 2^TPP_LOG2) × RATIO, clamped to 2^FINE_W − 1 and zero-extended. With the defaults (target 4, 16 taps per converter period, ratio 3) the code ranges from 0 to 31.
- R7: When `coarse_mode` is high at `start`, the block issues no `dly_load` pulse. After the sync pulse and the SYNC_WAIT cycles it writes the `saved_edge` value captured at start, zero-extended, to address COARSE_ADDR (default 0x13).
- R8: `wr_valid` stays high with `wr_addr` and `wr_data` unchanged until the cycle in which `wr_ready` is high. `busy` is high from the cycle after an accepted start until the cycle after that handshake.
- R9: `done` is high for exactly one cycle, the cycle after the write handshake. In that cycle `busy` and `wr_valid` are already low.
- R10: If the sweep passes the last tap without finding an edge, `err` rises, `busy` drops and no write is requested. `err` stays high until the next accepted start clears it.
- R11: After reset, `sync_out`, `dly_load`, `wr_valid`, `busy`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and control clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one alignment sequence |
| coarse_mode | input | 1 | Selects coarse-only restore instead of the sweep |
| saved_edge | input | COARSE_W | Stored coarse edge index written in coarse-only mode |
| sync_out | output | 1 | Divider-reset request to the clock generator |
| dly_load | output | 1 | Load strobe for the delay line |
| dly_tap | output | TAP_W | Tap value for the delay line |
| sysref_smp | input | 1 | Delayed SYSREF as seen by the sampling flop |
| wr_valid | output | 1 | Register write request valid |
| wr_ready | input | 1 | Register write request accepted |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | DATA_W | Register data of the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after a completed write |
| err | output | 1 | No transition found in the sweep |
| meas_tap | output | TAP_W | Measured edge tap |

## Verification
The sync pulse starts in the cycle after `start`. The first tap load comes SYNC_WAIT cycles after the sync pulse falls, and each later load comes 1+SETTLE+SAMPLES cycles after the one before it. `done` rises in the cycle after the handshake, and `err` rises in the cycle after the last tap's final sample. The bench samples on falling edges and counts those falling edges from `start`, from the sync fall and from the previous load, so every interval is compared with its exact value rather than with a window. For the write it waits for `wr_valid`, holds `wr_ready` low for a random number of cycles while checking that the request stays stable, then checks `done`, `busy` and `wr_valid` at the next falling edge and checks that `done` has fallen one edge later.

// File: rtl/sysref_align_pkg.sv
package sysref_align_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_WAIT,
        ST_LOAD,
        ST_SETTLE,
        ST_SAMPLE,
        ST_WRITE
    } align_state_e;

    // Outcome of one tap's sampling window
    typedef struct packed {
        logic last;   // final sample of the window is being taken
        logic level;  // majority decision, valid with last
    } tap_result_t;

    // Fine-delay code from a measured tap; period is a power of two
    function automatic int unsigned fine_code(
        input int unsigned meas,
        input int unsigned target,
        input int unsigned per_log2,
        input int unsigned ratio,
        input int unsigned max_code
    );
        int unsigned diff;
        int unsigned scaled;
        diff   = (target - meas) & ((32'd1 << per_log2) - 32'd1);
        scaled = diff * ratio;
        return (scaled > max_code) ? max_code : scaled;
    endfunction

endpackage

// File: rtl/sysref_tap_sampler.sv
module sysref_tap_sampler
    import sysref_align_pkg::*;
#(
    parameter int SAMPLES = 64,
    localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic        smp,
    output tap_result_t res
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ones_q;
    logic [CNT_W-1:0] ones_total;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            ones_q <= '0;
        end else if (en) begin
            cnt_q  <= cnt_q + 1'b1;
            ones_q <= ones_q + CNT_W'(smp);
        end
    end

    always_comb begin
        ones_total = ones_q + CNT_W'(smp);
        res.last   = en && (cnt_q == CNT_W'(SAMPLES - 1));
        res.level  = (ones_total > CNT_W'(SAMPLES / 2));
    end

    AST_SAMPLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < CNT_W'(SAMPLES))); // R3

endmodule

// File: rtl/sysref_edge_finder.sv
module sysref_edge_finder (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic level,
    output logic hit
);

    logic have_prev_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_prev_q <= 1'b0;
            prev_q      <= 1'b0;
        end else if (step) begin
            have_prev_q <= 1'b1;
            prev_q      <= level;
        end
    end

    assign hit = step && have_prev_q && !prev_q && level;

    AST_FIRST_TAP_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (clear ##1 step) |-> !hit); // R5

endmodule

// File: rtl/sysref_phase_aligner.sv
module sysref_phase_aligner
    import sysref_align_pkg::*;
#(
    parameter int NUM_TAPS    = 32,
    parameter int SAMPLES     = 64,
    parameter int SETTLE      = 8,
    parameter int SYNC_LEN    = 4,
    parameter int SYNC_WAIT   = 16,
    parameter int TPP_LOG2    = 4,
    parameter int TARGET_TAP  = 4,
    parameter int RATIO       = 3,
    parameter int FINE_W      = 5,
    parameter int COARSE_W    = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int FINE_ADDR   = 'h12,
    parameter int COARSE_ADDR = 'h13,
    localparam int TAP_W      = $clog2(NUM_TAPS),
    localparam int MAX_WAIT   = (SYNC_LEN > SYNC_WAIT)
                                ? ((SYNC_LEN > SETTLE) ? SYNC_LEN : SETTLE)
                                : ((SYNC_WAIT > SETTLE) ? SYNC_WAIT : SETTLE),
    localparam int CNT_W      = $clog2(MAX_WAIT + 1),
    localparam int FINE_MAX   = (1 << FINE_W) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                coarse_mode,
    input  logic [COARSE_W-1:0] saved_edge,
    output logic                sync_out,
    output logic                dly_load,
    output logic [TAP_W-1:0]    dly_tap,
    input  logic                sysref_smp,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [TAP_W-1:0]    meas_tap
);

    align_state_e        state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [TAP_W-1:0]    tap_q;
    logic                mode_q;
    logic [COARSE_W-1:0] saved_q;
    tap_result_t         tap_res;
    logic                edge_hit;

    sysref_tap_sampler #(
        .SAMPLES(SAMPLES)
    ) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .clear(state_q == ST_LOAD),
        .en   (state_q == ST_SAMPLE),
        .smp  (sysref_smp),
        .res  (tap_res)
    );

    sysref_edge_finder u_finder (
        .clk  (clk),
        .rst  (rst),
        .clear(state_q == ST_SYNC),
        .step (tap_res.last),
        .level(tap_res.level),
        .hit  (edge_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            tap_q    <= '0;
            mode_q   <= 1'b0;
            saved_q  <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            meas_tap <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SYNC;
                        cnt_q   <= CNT_W'(SYNC_LEN - 1);
                        tap_q   <= '0;
                        mode_q  <= coarse_mode;
                        saved_q <= saved_edge;
                        err     <= 1'b0;
                    end
                end
                ST_SYNC: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= CNT_W'(SYNC_WAIT - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (mode_q) begin
                        state_q  <= ST_WRITE;
                        wr_valid <= 1'b1;
                        wr_addr  <= ADDR_W'(COARSE_ADDR);
                        wr_data  <= DATA_W'(saved_q);
                    end else begin
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    state_q <= ST_SETTLE;
                    cnt_q   <= CNT_W'(SETTLE - 1);
                end
                ST_SETTLE: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_SAMPLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (tap_res.last) begin
                        if (edge_hit) begin
                            state_q  <= ST_WRITE;
                            meas_tap <= tap_q;
                            wr_valid <= 1'b1;
                            wr_addr  <= ADDR_W'(FINE_ADDR);
                            wr_data  <= DATA_W'(fine_code(32'(tap_q), TARGET_TAP,
                                                          TPP_LOG2, RATIO, FINE_MAX));
                        end else if (tap_q == TAP_W'(NUM_TAPS - 1)) begin
                            state_q <= ST_IDLE;
                            err     <= 1'b1;
                        end else begin
                            state_q <= ST_LOAD;
                            tap_q   <= tap_q + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_ready) begin
                        state_q  <= ST_IDLE;
                        wr_valid <= 1'b0;
                        done     <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sync_out = (state_q == ST_SYNC);
    assign dly_load = (state_q == ST_LOAD);
    assign dly_tap  = tap_q;
    assign busy     = (state_q != ST_IDLE);

    AST_SYNC_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> busy); // R1
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dly_load |=> !dly_load); // R2
    AST_COARSE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q) |-> !dly_load); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !wr_valid)); // R9
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        err |-> (!wr_valid && !busy)); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!wr_valid && !done && !err && !busy)); // R11

endmodule

// File: tb/tb_sysref_phase_aligner.sv
module tb_sysref_phase_aligner;

    localparam int NT = 32;
    localparam int NS = 64;
    localparam int ST = 8;
    localparam int SL = 4;
    localparam int SW = 16;
    localparam int TG = 4;
    localparam int RT = 3;
    localparam int FMAX = 31;
    localparam int A_FINE = 'h12;
    localparam int A_COARSE = 'h13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       coarse_mode = 1'b0;
    logic [3:0] saved_edge = '0;
    logic       sync_out, dly_load, sysref_smp, wr_valid, wr_ready;
    logic [4:0] dly_tap, meas_tap;
    logic [7:0] wr_addr, wr_data;
    logic       busy, done, err;

    int lvl [NT];
    int cyc = 0;
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sysref_phase_aligner dut (
        .clk(clk), .rst(rst), .start(start), .coarse_mode(coarse_mode),
        .saved_edge(saved_edge), .sync_out(sync_out), .dly_load(dly_load),
        .dly_tap(dly_tap), .sysref_smp(sysref_smp), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err(err), .meas_tap(meas_tap)
    );

    // Delay line model: level 0/1 with a minority flip every 4th cycle, 2 = exact half
    always @(negedge clk) begin
        int l;
        cyc = cyc + 1;
        l = lvl[dly_tap];
        if (l == 2) sysref_smp = cyc[0];
        else sysref_smp = (l == 1) ? ((cyc % 4) != 0) : ((cyc % 4) == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_edge();
        for (int t = 1; t < NT; t++)
            if (lvl[t - 1] != 1 && lvl[t] == 1) return t;
        return -1;
    endfunction

    function automatic int exp_code(input int m);
        int d;
        d = ((TG - m) % 16 + 16) % 16;
        return (d * RT > FMAX) ? FMAX : d * RT;
    endfunction

    task automatic run(input bit coarse, input int saved, input int rdly, input bit poke);
        int n = 0, sync_cnt = 0, sync_rise = 0, sync_fall = 0, loads = 0, last_load = 0;
        int first_gap = -1, bad_tap = 0, bad_int = 0, e;
        bit fin = 0, prev_sync = 0, wrote = 0, saw_err = 0, unstable = 0, poked = 0;
        logic [7:0] a, d;
        e = coarse ? -1 : exp_edge();
        @(negedge clk);
        coarse_mode = coarse;
        saved_edge = 4'(saved);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && err == 1'b0, "R8 busy after start / R10 err cleared", busy, 1);
        while (!fin && n < 20000) begin
            if (sync_out) sync_cnt++;
            if (sync_out && !prev_sync) sync_rise++;
            if (prev_sync && !sync_out) sync_fall = n;
            if (dly_load) begin
                if (loads == 0) first_gap = n - sync_fall;
                else if (n - last_load != 1 + ST + NS) bad_int++;
                if (int'(dly_tap) != loads) bad_tap++;
                loads++;
                last_load = n;
            end
            if (wr_valid) begin
                wrote = 1;
                a = wr_addr;
                d = wr_data;
                for (int k = 0; k < rdly; k++) begin
                    @(negedge clk);
                    if (!wr_valid || wr_addr != a || wr_data != d) unstable = 1;
                end
                wr_ready = 1'b1;
                @(negedge clk);
                wr_ready = 1'b0;
                check(done && !busy && !wr_valid, "R9 done pulse after handshake", done, 1);
                @(negedge clk);
                check(!done, "R9 done lasts one cycle", done, 0);
                fin = 1;
            end else if (err) begin
                saw_err = 1;
                fin = 1;
            end
            if (!fin) begin
                prev_sync = sync_out;
                n++;
                @(negedge clk);
                if (poked && start) start = 1'b0;
                if (poke && !poked && loads == 2) begin
                    start = 1'b1;
                    poked = 1;
                end
            end
        end
        start = 1'b0;
        check(n < 20000, "watchdog run completion", n, 0);
        check(sync_cnt == SL && sync_rise == 1, "R1 sync length and single pulse", sync_cnt, SL);
        if (coarse) begin
            check(loads == 0, "R7 no tap loads in coarse mode", loads, 0);
            check(wrote && a == 8'(A_COARSE) && d == 8'(saved), "R7 coarse write", d, saved);
        end else begin
            check(first_gap == SW, "R2 first load gap", first_gap, SW);
            check(bad_tap == 0, "R2 tap order", bad_tap, 0);
            check(bad_int == 0, "R3 load interval", bad_int, 0);
            if (e < 0) begin
                check(saw_err && !wrote && !busy, "R10 error no write", wrote, 0);
                check(loads == NT, "R10 full sweep", loads, NT);
            end else begin
                check(loads == e + 1, "R5 sweep stops at edge / R4 majority", loads, e + 1);
                check(int'(meas_tap) == e, "R5 measured tap", meas_tap, e);
                check(wrote && a == 8'(A_FINE), "R6 fine address", a, A_FINE);
                check(int'(d) == exp_code(e), "R6 fine code", d, exp_code(e));
            end
        end
        check(!unstable, "R8 request held until ready", unstable, 0);
    endtask

    task automatic set_edge(input int e, input int half_before);
        for (int t = 0; t < NT; t++) lvl[t] = (t >= e) ? 1 : 0;
        if (half_before && e > 0) lvl[e - 1] = 2;
    endtask

    initial begin
        while (1) begin
            @(negedge clk);
            if (cyc > 190000) begin
                tests++;
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        int s;
        s = $urandom(1234);
        wr_ready = 1'b0;
        for (int t = 0; t < NT; t++) lvl[t] = 0;
        repeat (4) @(negedge clk);
        check(!sync_out && !dly_load && !wr_valid && !busy && !done && !err,
              "R11 reset outputs", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !err && !done, "R11 idle after reset", busy, 0);

        set_edge(TG, 0);          run(0, 0, 0, 0);  // R6 zero correction
        set_edge(TG + 1, 1);      run(0, 0, 2, 0);  // R4 half reads 0, R6 clamp
        set_edge(10, 0);          run(0, 0, 1, 1);  // R1 start while busy ignored
        set_edge(1, 0);           run(0, 0, 0, 0);  // R5 earliest edge
        set_edge(NT - 1, 0);      run(0, 0, 0, 0);  // R5 last tap
        set_edge(0, 0);           run(0, 0, 0, 0);  // R10 all high
        for (int t = 0; t < NT; t++) lvl[t] = 2;
        run(0, 0, 0, 0);                            // R4 R10 all half
        set_edge(21, 0);          run(0, 0, 3, 0);  // R6 wrap then clamp
        run(1, 9, 2, 0);                            // R7 coarse restore
        run(1, 15, 0, 1);                           // R7 R1

        for (int k = 0; k < 14; k++) begin
            if (k % 2 == 0) begin
                int e;
                e = $urandom_range(1, NT - 1);
                for (int t = 0; t < NT; t++)
                    lvl[t] = (t >= e) ? 1 : (($urandom % 3 == 0) ? 2 : 0);
            end else begin
                for (int t = 0; t < NT; t++) lvl[t] = $urandom % 3;
            end
            run(0, 0, $urandom_range(0, 4), k % 5 == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule